// File: doc/BRIEF.md
# Three-Wire Radio Register Serializer

This block writes one configuration word into a radio synthesizer over a three-wire link: a serial clock, a serial data line and a latch enable. A client offers a register address and a data value on a valid/ready handshake. Once accepted, the pair becomes one frame, address in the upper bits. The frame is shifted out most significant bit first, one bit per serial clock period. A trailing latch phase follows, in which the enable line is raised and a single extra clock pulse tells the receiver to commit the word.

Each bit takes three equal steps, each `HALF_PERIOD` system cycles long. In the first, data is driven with the clock low. In the second, the clock is high. In the third, the clock is low again, so the low time is twice the high time. The latch phase uses the same three steps with the enable high throughout. The receiver keeps the last bits shifted in: the top four select one of sixteen registers, and the lower twelve are written to it. While a frame is in flight the block is busy and ignores new requests.

Top module: `radio_cfg_serializer`

## Requirements
- R1: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. In the next cycle `req_ready` is low and `ser_data` carries address bit 3.
- R2: Frame bits leave in the order address bit 3 down to address bit 0, then data bit 11 down to data bit 0. Each bit occupies a window of 3*HALF_PERIOD cycles.
- R3: Within each bit window, `ser_clk` is low for HALF_PERIOD cycles, high for HALF_PERIOD cycles, then low for HALF_PERIOD cycles.
- R4: `ser_data` never changes while `ser_clk` is high.
- R5: Right after the sixteenth bit window, `ser_latch` is high for 3*HALF_PERIOD cycles. During that time `ser_clk` is low for HALF_PERIOD, high for HALF_PERIOD, then low for HALF_PERIOD. `ser_latch` is never raised while `ser_clk` is high.
- R6: A receiver that shifts `ser_data` in on each `ser_clk` rise with `ser_latch` low sees the frame {address, data}, 16 bits. On the `ser_clk` rise with `ser_latch` high, the upper 4 bits of those last 16 bits name the register and the lower 12 are its new value.
- R7: `req_ready` stays low for exactly 51*HALF_PERIOD cycles after acceptance. It goes high in the same cycle in which `ser_latch` falls.
- R8: A request presented while `req_ready` is low is dropped. It changes nothing on the serial lines and produces no later frame.
- R9: While idle, `ser_clk` and `ser_latch` are low and `ser_data` keeps the last bit sent (data bit 0 of the previous frame).
- R10: Reset is synchronous and active low. In the cycle after a clock edge that samples `rst_n` low, any frame in progress is abandoned, `ser_clk`, `ser_data` and `ser_latch` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | Idle and able to take a request |
| req_addr | input | ADDR_W (4) | Target register address |
| req_data | input | DATA_W (12) | Value to write |
| ser_clk | output | 1 | Serial clock; the receiver samples on its rising edge |
| ser_data | output | 1 | Serial data, MSB first |
| ser_latch | output | 1 | Latch enable, high during the commit phase |

## Verification
The bench targets the boundary between the last data bit and the latch phase. A sequencer that counts one bit too few or too many there would commit a shifted word, and the decoding receiver model would record the wrong address or value. It holds `req_valid` high across a busy frame with different contents. A design that took that request would start a second frame, and both the latch count and the cycle-by-cycle comparison would show it. It pulses reset in the middle of a bit window to catch a state that survives the reset. It also checks the data line during clock-high cycles, and the hold of the last bit while idle, to catch a design that changes data at the wrong moment.

// File: rtl/radio_cfg_pkg.sv
// Package: radio_cfg_pkg
// Shared step encoding and frame-shape constants for the three-wire
// radio register serializer. Assumes a frame of one address field
// followed by one data field, each bit spread over three equal steps.
package radio_cfg_pkg;

    // Steps a single serial bit (and the latch phase) is divided into.
    localparam int unsigned STEPS_PER_BIT = 3;

    // Sequencer step: three steps per data bit, three for the latch.
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_BIT_SETUP  = 3'd1,
        ST_BIT_HIGH   = 3'd2,
        ST_BIT_HOLD   = 3'd3,
        ST_LAT_SETUP  = 3'd4,
        ST_LAT_HIGH   = 3'd5,
        ST_LAT_HOLD   = 3'd6
    } step_e;

    // True for steps in which the serial clock is driven high.
    function automatic logic step_clk_high(input step_e s);
        return (s == ST_BIT_HIGH) || (s == ST_LAT_HIGH);
    endfunction

    // True for steps belonging to the trailing latch phase.
    function automatic logic step_in_latch(input step_e s);
        return (s == ST_LAT_SETUP) || (s == ST_LAT_HIGH) || (s == ST_LAT_HOLD);
    endfunction

endpackage

// File: rtl/sclk_step_timer.sv
// Module: sclk_step_timer
// Measures the length of one serial step in system clock cycles.
// Assumes STEP_CYCLES >= 1 (smaller values are clamped to 1). The
// expire flag is high in the last cycle of each step; a restart
// reloads the count so a fresh step starts in the next cycle.
module sclk_step_timer #(
    parameter int unsigned STEP_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expire
);
    localparam int unsigned LEN = (STEP_CYCLES < 1) ? 1 : STEP_CYCLES;
    localparam int unsigned CW  = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    // Flag the final cycle of the current step.
    always_comb begin
        expire = (cnt_q == '0);
    end

    // Down-count within a step, reloading at each step boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (restart || (run && expire)) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/cfg_frame_shifter.sv
// Module: cfg_frame_shifter
// Holds the frame being sent and presents its top bit as the serial
// data line. Assumes the sequencer loads once per frame and shifts
// only between bits, never after the last one, so the final bit stays
// on the line while idle.
module cfg_frame_shifter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] frame,
    input  logic             shift,
    output logic             bit_out
);
    logic [WIDTH-1:0] sh_q;

    // Load a new frame or move the next bit into the top position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= frame;
        end else if (shift) begin
            sh_q <= {sh_q[WIDTH-2:0], 1'b0};
        end
    end

    // Drive the serial data line from the top bit.
    always_comb begin
        bit_out = sh_q[WIDTH-1];
    end
endmodule

// File: rtl/cfg_write_sequencer.sv
// Module: cfg_write_sequencer
// Steps through the bit windows of one frame and the trailing latch
// phase. Assumes a step timer whose expire flag marks the last cycle
// of each step. Serial clock, latch and ready are decoded from the
// registered step, so they change only on clock edges.
module cfg_write_sequencer
    import radio_cfg_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic expire,
    output logic accept,
    output logic busy,
    output logic shift,
    output logic ready,
    output logic sclk,
    output logic latch
);
    localparam int unsigned BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    step_e         step_q, step_d;
    logic [BW-1:0] bit_q;
    logic          last_bit;

    // Handshake and per-step decode.
    always_comb begin
        ready    = (step_q == ST_IDLE);
        accept   = ready && req_valid;
        busy     = !ready;
        last_bit = (bit_q == LAST_BIT);
        shift    = (step_q == ST_BIT_HOLD) && expire && !last_bit;
        sclk     = step_clk_high(step_q);
        latch    = step_in_latch(step_q);
    end

    // Choose the next step from the current one and the timer.
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE:      if (accept) step_d = ST_BIT_SETUP;
            ST_BIT_SETUP: if (expire) step_d = ST_BIT_HIGH;
            ST_BIT_HIGH:  if (expire) step_d = ST_BIT_HOLD;
            ST_BIT_HOLD:  if (expire) step_d = last_bit ? ST_LAT_SETUP : ST_BIT_SETUP;
            ST_LAT_SETUP: if (expire) step_d = ST_LAT_HIGH;
            ST_LAT_HIGH:  if (expire) step_d = ST_LAT_HOLD;
            ST_LAT_HOLD:  if (expire) step_d = ST_IDLE;
            default:      step_d = ST_IDLE;
        endcase
    end

    // Register the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else begin
            step_q <= step_d;
        end
    end

    // Count the bits already sent in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (accept) begin
            bit_q <= '0;
        end else if (shift) begin
            bit_q <= bit_q + 1'b1;
        end
    end
endmodule

// File: rtl/radio_cfg_serializer.sv
// Module: radio_cfg_serializer
// Top level: takes an address/data pair on valid/ready, shifts it out
// MSB first on a three-wire link, then raises the latch enable for one
// extra clock pulse. Assumes HALF_PERIOD >= 1 system cycles per step
// and a receiver that samples data on the serial clock's rising edge.
module radio_cfg_serializer #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned HALF_PERIOD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch
);
    localparam int unsigned FRAME_BITS = ADDR_W + DATA_W;

    logic                  accept;
    logic                  busy;
    logic                  shift;
    logic                  expire;
    logic [FRAME_BITS-1:0] frame;

    // Address goes out first, so it takes the upper bits.
    always_comb begin
        frame = {req_addr, req_data};
    end

    sclk_step_timer #(
        .STEP_CYCLES (HALF_PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .expire  (expire)
    );

    cfg_write_sequencer #(
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .expire    (expire),
        .accept    (accept),
        .busy      (busy),
        .shift     (shift),
        .ready     (req_ready),
        .sclk      (ser_clk),
        .latch     (ser_latch)
    );

    cfg_frame_shifter #(
        .WIDTH (FRAME_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .frame   (frame),
        .shift   (shift),
        .bit_out (ser_data)
    );
endmodule

// File: rtl/radio_cfg_serializer_chk.sv
// Module: radio_cfg_serializer_chk
// Protocol checker for the serializer's ports, bound to every instance.
// Assumes a 16-bit frame; counts serial clock rises to confirm that the
// latch pulse comes after exactly one frame of bits.
module radio_cfg_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_latch
);
    logic [4:0] rises_q;
    logic       clk_prev_q;

    // Count data-bit clock rises since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rises_q    <= '0;
            clk_prev_q <= 1'b0;
        end else begin
            clk_prev_q <= ser_clk;
            if (req_valid && req_ready) begin
                rises_q <= '0;
            end else if (ser_clk && !clk_prev_q && !ser_latch) begin
                rises_q <= rises_q + 1'b1;
            end
        end
    end

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data));

    assert_latch_rise_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_latch) |-> !ser_clk);

    assert_sixteen_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !clk_prev_q && ser_latch) |-> (rises_q == 5'd16));

    assert_ready_on_latch_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_latch) |-> req_ready);

    assert_ready_rise_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_ready) && $past(rst_n)) |-> $fell(ser_latch));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ser_clk && !ser_latch));

    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !ser_clk && !ser_latch && !ser_data));
endmodule

bind radio_cfg_serializer radio_cfg_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch)
);

// File: tb/radio_cfg_serializer_test.sv
// Bench: behavioural reference model compared with the design at every
// falling clock edge, plus a decoding receiver on the serial lines.
module radio_cfg_serializer_test;
    localparam int HALF  = 3;
    localparam int BUSY  = 51 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [11:0] req_data = '0;
    logic        req_ready, ser_clk, ser_data, ser_latch;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    radio_cfg_serializer #(.ADDR_W(4), .DATA_W(12), .HALF_PERIOD(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch));

    // Reference model state.
    bit          m_busy = 0;
    int          m_k = 0;
    logic [15:0] m_frame = '0;
    logic        m_last = 1'b0;
    logic [15:0] exp_q[$];
    int          commits = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model: advance the frame position on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_last = 1'b0; exp_q.delete();
        end else if (m_busy) begin
            m_k++;
            if (m_k == BUSY) m_busy = 0;
        end else if (req_valid) begin
            m_busy = 1; m_k = 0; m_frame = {req_addr, req_data};
            exp_q.push_back(m_frame);
        end
        if (m_busy && (m_k / HALF) < 48) m_last = m_frame[15 - (m_k / HALF) / 3];
    end

    // Compare every cycle and run the receiver model.
    logic [15:0] rx = '0;
    logic        prev_clk = 1'b0;
    logic        prev_data = 1'b0;
    always @(negedge clk) begin
        int p;
        logic e_clk, e_le, e_rdy;
        p     = m_k / HALF;
        e_clk = m_busy && ((p < 48 && p % 3 == 1) || p == 49);
        e_le  = m_busy && p >= 48;
        e_rdy = !m_busy;
        check(ser_clk === e_clk, m_busy ? "R3" : "R9", ser_clk, e_clk);
        check(ser_latch === e_le, m_busy ? "R5" : "R9", ser_latch, e_le);
        check(req_ready === e_rdy, "R7", req_ready, e_rdy);
        check(ser_data === m_last, m_busy ? "R2" : "R9", ser_data, m_last);
        if (ser_clk === 1'b1)
            check(ser_data === prev_data, "R4", ser_data, prev_data);
        if (!rst_n) begin
            rx = '0;
        end else if (ser_clk === 1'b1 && prev_clk === 1'b0) begin
            if (ser_latch === 1'b1) begin
                logic [15:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
                commits++;
                check(rx[15:12] === e[15:12], "R6 addr", rx[15:12], e[15:12]);
                check(rx[11:0] === e[11:0], "R6 data", rx[11:0], e[11:0]);
            end else begin
                rx = {rx[14:0], ser_data};
            end
        end
        prev_clk  = ser_clk;
        prev_data = ser_data;
    end

    task automatic send(input logic [3:0] a, input logic [11:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        while (req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0 && ser_data === a[3], "R1", {req_ready, ser_data}, {1'b0, a[3]});
    endtask

    task automatic wait_idle();
        while (req_ready !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && ser_clk === 1'b0 && ser_latch === 1'b0 && ser_data === 1'b0,
              "R10 reset", {req_ready, ser_clk, ser_latch, ser_data}, 4'b1000);
        rst_n = 1'b1;
        send(4'h3, 12'h0A5);
        send(4'hF, 12'hFFF);
        send(4'h0, 12'h000);
        send(4'h5, 12'h5A3);
        wait_idle();
        check(commits == 4, "R6 count", commits, 4);
        // R9: idle line keeps data bit 0 of the last frame (1).
        check(ser_data === 1'b1, "R9 hold", ser_data, 1);

        // R8: a request during a busy frame must be dropped.
        send(4'hA, 12'h321);
        repeat (30) @(negedge clk);
        req_valid = 1'b1; req_addr = 4'h6; req_data = 12'hBEE;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        check(commits == 5, "R8 dropped", commits, 5);

        // R10: reset in the middle of a bit window abandons the frame.
        send(4'h9, 12'hC3C);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1 && ser_clk === 1'b0 && ser_latch === 1'b0 && ser_data === 1'b0,
              "R10 abort", {req_ready, ser_clk, ser_latch, ser_data}, 4'b1000);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(commits == 5, "R10 no commit", commits, 5);
        send(4'hC, 12'h801);
        wait_idle();
        check(commits == 6, "R6 after reset", commits, 6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule